// File: doc/BRIEF.md
# Status Flag Update Unit

This block holds the five condition flags of a DSP data path: negative (N), zero (Z), overflow (V), carry (C) and a sticky overflow latch (L). Each cycle the data path may present a completed operation. It gives an operation class, a destination type, the 36-bit result word, the carry and overflow indications from the adder, and the bit that a one-bit shift or rotate pushed out. A valid strobe qualifies the operation. On the next clock edge the unit rewrites only the flags that the operation class is allowed to touch.

Flags for a 16-bit destination always come from the low 16 bits of the result. This applies to a register or a memory word. A logical operation that targets the 36-bit accumulator takes its flags from the middle word instead: bits 31:16. Bit-field operations touch only C. Clearing an accumulator produces a fixed flag pattern. Clearing any other register, and the classes handled elsewhere, leave the flags untouched. These other classes are divide steps, multi-bit shifts, integer multiply and arithmetic into a full accumulator.

Top module: `status_flag_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears N, Z, V, C and L to 0. The reset wins over a valid operation presented in the same cycle.
- R2: When `valid` is low at a clock edge, no flag changes.
- R3: Arithmetic class (`op_class`=1) into a 16-bit destination (`dst_sel` other than 2) sets the flags as follows: N = `result[15]`, Z = (`result[15:0]`==0), V = `ovf_in`, C = `carry_in`. Bits above 15 of the result have no effect.
- R4: Arithmetic class into the accumulator (`dst_sel`=2) leaves all flags unchanged.
- R5: Logical class (`op_class`=2) into a 16-bit destination sets N = `result[15]`, Z = (`result[15:0]`==0) and V = 0, and leaves C unchanged.
- R6: Logical class into the accumulator sets N = `result[31]`, Z = (`result[31:16]`==0) and V = 0, and leaves C unchanged.
- R7: Shift/rotate class (`op_class`=3) sets N, Z and V as in R5 or R6, chosen by destination, and loads C with `shift_out`.
- R8: Bit-field class (`op_class`=4) loads C with `carry_in`. N, Z, V and L stay unchanged, even when `ovf_in` is high.
- R9: Clear class (`op_class`=5) into the accumulator sets Z=1 and N=V=C=0, and leaves L unchanged.
- R10: Clear class into any non-accumulator destination leaves all flags unchanged.
- R11: Classes 0, 6 and 7 leave all flags unchanged. Class 6 covers divide, multi-bit shift and integer multiply.
- R12: L is set whenever an update writes V=1. Only reset clears L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Operation present this cycle |
| op_class | input | 3 | Operation class code |
| dst_sel | input | 2 | Destination type (2 = accumulator, else 16-bit) |
| result | input | 36 | Result word of the operation |
| carry_in | input | 1 | Carry/borrow out of bit 15, or bit-field test result |
| ovf_in | input | 1 | Signed 16-bit overflow from the arithmetic path |
| shift_out | input | 1 | Bit shifted or rotated out |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| flag_l | output | 1 | Sticky overflow latch |

## Verification
Reset and an overflowing arithmetic update can arrive in the same cycle. Two things then compete: the L latch is being set, and every flag is being cleared. The bench first sets L and then raises `rst` together with a valid arithmetic operation that has `ovf_in` high. It expects all five flags at zero one cycle later. It then issues a further overflow with reset released, to show that L sets again, and a clean arithmetic operation, to show that L holds.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

  typedef enum logic [2:0] {
    OPC_NONE  = 3'd0,
    OPC_ARITH = 3'd1,
    OPC_LOGIC = 3'd2,
    OPC_SHIFT = 3'd3,
    OPC_BITF  = 3'd4,
    OPC_CLEAR = 3'd5,
    OPC_HOLD  = 3'd6,
    OPC_RSVD  = 3'd7
  } opc_e;

  typedef enum logic [1:0] {
    DST_REG  = 2'd0,
    DST_MEM  = 2'd1,
    DST_ACC  = 2'd2,
    DST_RSVD = 2'd3
  } dst_e;

  // source for the next C value
  typedef enum logic [1:0] {
    CSRC_KEEP  = 2'd0,
    CSRC_CARRY = 2'd1,
    CSRC_SHIFT = 2'd2
  } csrc_e;

  typedef struct packed {
    logic  wr_nz;     // rewrite N and Z
    logic  nz_mid;    // take N/Z from the middle word
    logic  wr_v;      // rewrite V
    logic  v_zero;    // V forced to 0 when rewritten
    logic  force_clr; // fixed pattern of an accumulator clear
    csrc_e csrc;
  } upd_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
    logic l;
  } flags_t;

endpackage

// File: rtl/sfu_decode.sv
module sfu_decode
  import sfu_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] op_class,
  input  logic [1:0] dst_sel,
  output upd_t       upd
);

  logic to_acc;
  assign to_acc = (dst_sel == DST_ACC);

  always_comb begin
    upd = '{wr_nz: 1'b0, nz_mid: 1'b0, wr_v: 1'b0, v_zero: 1'b0,
            force_clr: 1'b0, csrc: CSRC_KEEP};
    if (valid) begin
      case (op_class)
        OPC_ARITH: begin
          // accumulator-wide arithmetic is handled elsewhere
          if (!to_acc) begin
            upd.wr_nz = 1'b1;
            upd.wr_v  = 1'b1;
            upd.csrc  = CSRC_CARRY;
          end
        end
        OPC_LOGIC: begin
          upd.wr_nz  = 1'b1;
          upd.nz_mid = to_acc;
          upd.wr_v   = 1'b1;
          upd.v_zero = 1'b1;
        end
        OPC_SHIFT: begin
          upd.wr_nz  = 1'b1;
          upd.nz_mid = to_acc;
          upd.wr_v   = 1'b1;
          upd.v_zero = 1'b1;
          upd.csrc   = CSRC_SHIFT;
        end
        OPC_BITF:  upd.csrc = CSRC_CARRY;
        OPC_CLEAR: upd.force_clr = to_acc;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sfu_calc.sv
module sfu_calc
  import sfu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 36
) (
  input  flags_t             cur,
  input  upd_t               upd,
  input  logic [ACC_W-1:0]   result,
  input  logic               carry_in,
  input  logic               ovf_in,
  input  logic               shift_out,
  output flags_t             nxt,
  output logic               l_trip
);

  localparam int MID_LO = DATA_W;
  localparam int MID_HI = 2*DATA_W - 1;

  function automatic logic word_neg(input logic [DATA_W-1:0] w);
    return w[DATA_W-1];
  endfunction

  function automatic logic word_zero(input logic [DATA_W-1:0] w);
    return (w == '0);
  endfunction

  logic [DATA_W-1:0] sel_word;
  assign sel_word = upd.nz_mid ? result[MID_HI:MID_LO] : result[DATA_W-1:0];

  // an update that writes V=1 trips the sticky latch
  assign l_trip = upd.wr_v && !upd.v_zero && ovf_in;

  always_comb begin
    nxt = cur;
    if (upd.force_clr) begin
      nxt.n = 1'b0;
      nxt.z = 1'b1;
      nxt.v = 1'b0;
      nxt.c = 1'b0;
    end else begin
      if (upd.wr_nz) begin
        nxt.n = word_neg(sel_word);
        nxt.z = word_zero(sel_word);
      end
      if (upd.wr_v) nxt.v = upd.v_zero ? 1'b0 : ovf_in;
      case (upd.csrc)
        CSRC_CARRY: nxt.c = carry_in;
        CSRC_SHIFT: nxt.c = shift_out;
        default:    nxt.c = cur.c;
      endcase
    end
    nxt.l = cur.l | l_trip;
  end

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import sfu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [2:0]       op_class,
  input  logic [1:0]       dst_sel,
  input  logic [ACC_W-1:0] result,
  input  logic             carry_in,
  input  logic             ovf_in,
  input  logic             shift_out,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c,
  output logic             flag_l
);

  upd_t   upd;
  flags_t flags_q, flags_d;
  logic   l_trip;

  sfu_decode u_decode (
    .valid    (valid),
    .op_class (op_class),
    .dst_sel  (dst_sel),
    .upd      (upd)
  );

  sfu_calc #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_calc (
    .cur       (flags_q),
    .upd       (upd),
    .result    (result),
    .carry_in  (carry_in),
    .ovf_in    (ovf_in),
    .shift_out (shift_out),
    .nxt       (flags_d),
    .l_trip    (l_trip)
  );

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_v = flags_q.v;
  assign flag_c = flags_q.c;
  assign flag_l = flags_q.l;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags_q == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(flags_q));

  // R12
  sticky_l_chk: assert property (@(posedge clk) disable iff (rst)
    flags_q.l |=> flags_q.l);

  // R12
  l_trip_chk: assert property (@(posedge clk) disable iff (rst)
    l_trip |=> flags_q.l);

  // R8
  bitf_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && op_class == OPC_BITF) |=>
      $stable({flags_q.n, flags_q.z, flags_q.v, flags_q.l}));

  // R5
  logic_v_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && (op_class == OPC_LOGIC || op_class == OPC_SHIFT)) |=> !flags_q.v);

  // R9
  clr_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && op_class == OPC_CLEAR && dst_sel == DST_ACC) |=>
      (flags_q.z && !flags_q.n && !flags_q.v && !flags_q.c));

endmodule

// File: tb/status_flag_unit_tb.sv
`timescale 1ns/1ps
module status_flag_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [2:0]  op_class = '0;
  logic [1:0]  dst_sel = '0;
  logic [35:0] result = '0;
  logic        carry_in = 1'b0, ovf_in = 1'b0, shift_out = 1'b0;
  logic        flag_n, flag_z, flag_v, flag_c, flag_l;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  status_flag_unit u_dut (
    .clk(clk), .rst(rst), .valid(valid), .op_class(op_class), .dst_sel(dst_sel),
    .result(result), .carry_in(carry_in), .ovf_in(ovf_in), .shift_out(shift_out),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c), .flag_l(flag_l)
  );

  // entry: op[48:46] dst[45:44] result[43:8] cy[7] ov[6] sh[5] expected {n,z,v,c,l}[4:0]
  localparam int NV = 15;
  localparam logic [48:0] VEC [NV] = '{
    {3'd1, 2'd0, 36'h0_0000_8000, 1'b1, 1'b0, 1'b0, 5'b10010}, // R3 negative, carry
    {3'd1, 2'd1, 36'h0_1234_0000, 1'b0, 1'b1, 1'b0, 5'b01101}, // R3 zero low word, R12 trip
    {3'd2, 2'd0, 36'h0_0000_0001, 1'b1, 1'b1, 1'b1, 5'b00001}, // R5 V cleared, C kept
    {3'd3, 2'd0, 36'h0_0000_0000, 1'b0, 1'b0, 1'b1, 5'b01011}, // R7 C from shift_out
    {3'd2, 2'd2, 36'hF_8000_FFFF, 1'b0, 1'b1, 1'b0, 5'b10011}, // R6 N from bit 31
    {3'd2, 2'd2, 36'h0_0000_FFFF, 1'b0, 1'b0, 1'b0, 5'b01011}, // R6 Z from 31:16
    {3'd4, 2'd0, 36'h0_0000_8000, 1'b0, 1'b1, 1'b0, 5'b01001}, // R8 only C
    {3'd3, 2'd2, 36'h0_8000_0000, 1'b1, 1'b0, 1'b0, 5'b10001}, // R7 accumulator
    {3'd5, 2'd0, 36'h0_0000_0000, 1'b1, 1'b1, 1'b1, 5'b10001}, // R10 clear non-acc
    {3'd5, 2'd2, 36'h0_0000_0000, 1'b1, 1'b1, 1'b1, 5'b01001}, // R9 clear acc, L kept
    {3'd6, 2'd0, 36'h0_0000_8000, 1'b1, 1'b1, 1'b1, 5'b01001}, // R11 hold class
    {3'd1, 2'd2, 36'h0_0000_8000, 1'b1, 1'b1, 1'b0, 5'b01001}, // R4 arith into acc
    {3'd1, 2'd0, 36'h0_0001_7FFF, 1'b0, 1'b0, 1'b0, 5'b00001}, // R3 upper bits ignored
    {3'd4, 2'd2, 36'h0_0000_0000, 1'b1, 1'b0, 1'b0, 5'b00011}, // R8 bit-field sets C
    {3'd3, 2'd1, 36'h0_0000_8000, 1'b1, 1'b0, 1'b0, 5'b10001}  // R7 memory word
  };

  task automatic check(input string req, input logic [4:0] exp);
    logic [4:0] got;
    got = {flag_n, flag_z, flag_v, flag_c, flag_l};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: flags nzvcl got %b expected %b", req, got, exp);
    end
  endtask

  // drive at a falling edge; the result is visible at the next falling edge
  task automatic drive(input logic v, input logic [2:0] op, input logic [1:0] d,
                       input logic [35:0] r, input logic cy, input logic ov, input logic sh);
    valid = v; op_class = op; dst_sel = d; result = r;
    carry_in = cy; ovf_in = ov; shift_out = sh;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 5'b00000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][48:46], VEC[i][45:44], VEC[i][43:8],
            VEC[i][7], VEC[i][6], VEC[i][5]);
      check($sformatf("vector %0d", i), VEC[i][4:0]);
    end

    // R2: valid low with an overflowing arithmetic request
    drive(1'b0, 3'd1, 2'd0, 36'h0, 1'b1, 1'b1, 1'b1);
    check("R2 idle", 5'b10001);

    // R11: reserved class 7 and class 0
    drive(1'b1, 3'd7, 2'd0, 36'h0, 1'b1, 1'b1, 1'b1);
    check("R11 class 7", 5'b10001);
    drive(1'b1, 3'd0, 2'd2, 36'h0, 1'b1, 1'b1, 1'b1);
    check("R11 class 0", 5'b10001);

    // R1 with R12: reset and overflowing update together, reset wins
    rst = 1'b1;
    drive(1'b1, 3'd1, 2'd0, 36'h0_0000_FFFF, 1'b1, 1'b1, 1'b0);
    check("R1 reset beats update", 5'b00000);
    rst = 1'b0;

    // R12: overflow sets L again, then a clean update keeps it
    drive(1'b1, 3'd1, 2'd0, 36'h0_0000_FFFF, 1'b1, 1'b1, 1'b0);
    check("R12 trip after reset", 5'b10111);
    drive(1'b1, 3'd1, 2'd1, 36'h0_0000_0000, 1'b0, 1'b0, 1'b0);
    check("R12 sticky", 5'b01001);

    // R5: reserved destination code behaves as 16-bit
    drive(1'b1, 3'd2, 2'd3, 36'h0_0000_8000, 1'b1, 1'b1, 1'b1);
    check("R5 dst 3", 5'b10001);

    valid = 1'b0;
    finish_run();
  end

endmodule